// File: doc/BRIEF.md
# SIMT Reconvergence Stack

This block keeps the control-flow state of one warp whose threads may take different ways through a branch. Each stack level records three things: the program counter at which the split paths join again (or no such PC for the bottom level), the next program counter to fetch for that level, and the subset of threads that run on it. The top level always supplies the fetch PC and the thread-enable mask for the warp. Thread i of the warp is bit i of every mask.

Two streams come in. A branch stream delivers the resolved outcome of a branch: which threads take it, the taken target, the fall-through PC and the join PC. A PC stream reports each PC the warp moves on to. When the branch splits the active threads, the top level is redirected to the join PC and one level is pushed for each path, with the busier path on top so that it runs first. When the warp reaches the join PC of the top level, that level is dropped and the level beneath takes over. Both streams use valid/ready. A beat moves only in a cycle where valid and ready are both high. Ready depends only on other inputs in the same cycle: the branch stream stalls only while a launch is applied, and the PC stream also stalls while a branch beat is offered. A producer must hold a stalled beat steady until it is taken.

A push that would go past the configured depth is refused. The stack is left as it was, and a sticky error flag is raised. Only reset or a new launch clears the flag.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset the stack holds one level with no join PC, fetch PC equal to parameter RESET_PC and an all-ones mask. Depth reads 1 and the overflow flag is low.
- R2: A launch sets the stack back to one level with no join PC, fetch PC equal to the launch PC and an all-ones mask, and clears the overflow flag. While a launch is applied both ready outputs are low.
- R3: An accepted PC beat that differs from the top level's join PC becomes the top level's next PC, and the depth is unchanged. The bottom level has no join PC and is never popped.
- R4: An accepted PC beat equal to the top level's join PC removes the top level. From the next cycle the fetch PC and mask come from the level beneath.
- R5: A branch is uniform when its taken mask ANDed with the active mask is either zero or equal to the active mask. A uniform branch sets the top level's next PC to the fall-through PC (when zero) or to the taken PC (when equal) and pushes nothing. Taken bits of inactive threads have no effect.
- R6: A divergent branch rewrites the top level's next PC to the join PC. It then pushes two levels, each holding the join PC, one with the taken threads and taken PC and one with the remaining active threads and the fall-through PC, so the depth grows by 2. The active mask is never empty.
- R7: Of the two pushed levels, the one with more threads is on top. On a tie the taken path is on top.
- R8: A divergent branch accepted when the depth plus 2 exceeds DEPTH leaves every level and the depth unchanged, and sets the overflow flag. The flag then stays high until reset or launch. A push that fills the stack exactly to DEPTH is accepted.
- R9: When branch and PC beats are offered in the same cycle, the branch beat is taken and the PC stream sees ready low. The PC beat is taken in a later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| launch_i | input | 1 | Restart the warp at launch_pc_i |
| launch_pc_i | input | PC_W | Start PC for a launch |
| br_valid_i | input | 1 | Branch beat offered |
| br_ready_o | output | 1 | Branch beat can be taken |
| br_taken_mask_i | input | WARP_W | Threads that take the branch |
| br_taken_pc_i | input | PC_W | Branch target |
| br_fall_pc_i | input | PC_W | Fall-through PC |
| br_reconv_pc_i | input | PC_W | PC at which the two paths join |
| pc_valid_i | input | 1 | PC-advance beat offered |
| pc_ready_o | output | 1 | PC-advance beat can be taken |
| pc_i | input | PC_W | PC the warp has moved on to |
| fetch_pc_o | output | PC_W | Next PC of the top level |
| active_mask_o | output | WARP_W | Thread mask of the top level |
| depth_o | output | $clog2(DEPTH+1) | Number of levels in use |
| overflow_o | output | 1 | Sticky refused-push flag |

## Verification
A branch beat and a PC beat can arrive in the same cycle. The branch wins, so one of the two state changes must wait. The bench provokes this by offering a non-divergent branch together with a PC equal to the top level's join PC. It judges the outcome in three places. In that cycle, before the edge, the PC stream's ready must be low. After the edge, the fetch PC must be the branch's fall-through PC with the depth unchanged, which shows the held-off PC did not pop. In the next cycle the PC beat is taken alone and the pop shows as a depth one lower, with the fetch PC of the level beneath.

// File: rtl/rs_pkg.sv
package rs_pkg;

  // Stack operation chosen by the control logic for one cycle.
  typedef enum logic [2:0] {
    RS_OP_IDLE,
    RS_OP_SET_TOP,
    RS_OP_POP,
    RS_OP_DIVERGE,
    RS_OP_LAUNCH
  } rs_op_e;

endpackage

// File: rtl/rs_popcount.sv
module rs_popcount #(
  parameter int W  = 4,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  bits_i,
  output logic [CW-1:0] count_o
);

  always_comb begin
    count_o = '0;
    for (int k = 0; k < W; k++) begin
      count_o = count_o + CW'(bits_i[k]);
    end
  end

endmodule

// File: rtl/rs_branch_eval.sv
module rs_branch_eval #(
  parameter int WARP_W = 4,
  parameter int PC_W   = 16
) (
  input  logic [WARP_W-1:0] active_i,
  input  logic [WARP_W-1:0] taken_mask_i,
  input  logic [PC_W-1:0]   taken_pc_i,
  input  logic [PC_W-1:0]   fall_pc_i,
  output logic              uniform_o,
  output logic [PC_W-1:0]   uniform_pc_o,
  output logic [WARP_W-1:0] hi_mask_o,
  output logic [PC_W-1:0]   hi_pc_o,
  output logic [WARP_W-1:0] lo_mask_o,
  output logic [PC_W-1:0]   lo_pc_o
);

  localparam int CW = $clog2(WARP_W + 1);

  logic [WARP_W-1:0] take_set;
  logic [WARP_W-1:0] stay_set;
  logic [CW-1:0]     take_cnt;
  logic [CW-1:0]     stay_cnt;
  logic              taken_first;

  assign take_set = taken_mask_i & active_i;
  assign stay_set = active_i & ~taken_mask_i;

  rs_popcount #(.W(WARP_W), .CW(CW)) u_cnt_take (
    .bits_i  (take_set),
    .count_o (take_cnt)
  );

  rs_popcount #(.W(WARP_W), .CW(CW)) u_cnt_stay (
    .bits_i  (stay_set),
    .count_o (stay_cnt)
  );

  assign uniform_o    = (take_set == '0) || (stay_set == '0);
  assign uniform_pc_o = (take_set == '0) ? fall_pc_i : taken_pc_i;

  // Busier path on top; a tie favours the taken path.
  assign taken_first = (take_cnt >= stay_cnt);

  assign hi_mask_o = taken_first ? take_set   : stay_set;
  assign hi_pc_o   = taken_first ? taken_pc_i : fall_pc_i;
  assign lo_mask_o = taken_first ? stay_set   : take_set;
  assign lo_pc_o   = taken_first ? fall_pc_i  : taken_pc_i;

endmodule

// File: rtl/rs_entry_file.sv
module rs_entry_file
  import rs_pkg::*;
#(
  parameter int              WARP_W   = 4,
  parameter int              PC_W     = 16,
  parameter int              DEPTH    = 8,
  parameter logic [PC_W-1:0] RESET_PC = '0,
  parameter int              CW       = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rs_op_e            op_i,
  input  logic [PC_W-1:0]   set_pc_i,
  input  logic [PC_W-1:0]   launch_pc_i,
  input  logic [PC_W-1:0]   rpc_i,
  input  logic [PC_W-1:0]   hi_pc_i,
  input  logic [WARP_W-1:0] hi_mask_i,
  input  logic [PC_W-1:0]   lo_pc_i,
  input  logic [WARP_W-1:0] lo_mask_i,
  output logic [PC_W-1:0]   top_rpc_o,
  output logic              top_rpc_valid_o,
  output logic [PC_W-1:0]   top_pc_o,
  output logic [WARP_W-1:0] top_mask_o,
  output logic [CW-1:0]     depth_o
);

  logic [CW-1:0]            cnt_q;
  logic [CW-1:0]            top_idx;
  logic [DEPTH*PC_W-1:0]    rpc_flat;
  logic [DEPTH-1:0]         rpcv_flat;
  logic [DEPTH*PC_W-1:0]    nxt_flat;
  logic [DEPTH*WARP_W-1:0]  msk_flat;

  assign top_idx = cnt_q - CW'(1);
  assign depth_o = cnt_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
    localparam logic [CW-1:0] IDX = CW'(i);
    logic [PC_W-1:0]   rpc_r;
    logic              rpcv_r;
    logic [PC_W-1:0]   nxt_r;
    logic [WARP_W-1:0] msk_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rpc_r  <= '0;
        rpcv_r <= 1'b0;
        nxt_r  <= (i == 0) ? RESET_PC : '0;
        msk_r  <= (i == 0) ? '1 : '0;
      end else begin
        case (op_i)
          RS_OP_LAUNCH: begin
            if (i == 0) begin
              rpc_r  <= '0;
              rpcv_r <= 1'b0;
              nxt_r  <= launch_pc_i;
              msk_r  <= '1;
            end
          end
          RS_OP_SET_TOP: begin
            if (IDX == top_idx) nxt_r <= set_pc_i;
          end
          RS_OP_DIVERGE: begin
            if (IDX == top_idx) begin
              nxt_r <= rpc_i;
            end else if (IDX == top_idx + CW'(1)) begin
              rpc_r  <= rpc_i;
              rpcv_r <= 1'b1;
              nxt_r  <= lo_pc_i;
              msk_r  <= lo_mask_i;
            end else if (IDX == top_idx + CW'(2)) begin
              rpc_r  <= rpc_i;
              rpcv_r <= 1'b1;
              nxt_r  <= hi_pc_i;
              msk_r  <= hi_mask_i;
            end
          end
          default: ;
        endcase
      end
    end

    assign rpc_flat[i*PC_W +: PC_W]     = rpc_r;
    assign rpcv_flat[i]                 = rpcv_r;
    assign nxt_flat[i*PC_W +: PC_W]     = nxt_r;
    assign msk_flat[i*WARP_W +: WARP_W] = msk_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CW'(1);
    end else begin
      case (op_i)
        RS_OP_LAUNCH:  cnt_q <= CW'(1);
        RS_OP_POP:     cnt_q <= cnt_q - CW'(1);
        RS_OP_DIVERGE: cnt_q <= cnt_q + CW'(2);
        default: ;
      endcase
    end
  end

  always_comb begin
    top_rpc_o       = '0;
    top_rpc_valid_o = 1'b0;
    top_pc_o        = '0;
    top_mask_o      = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (CW'(k) == top_idx) begin
        top_rpc_o       = rpc_flat[k*PC_W +: PC_W];
        top_rpc_valid_o = rpcv_flat[k];
        top_pc_o        = nxt_flat[k*PC_W +: PC_W];
        top_mask_o      = msk_flat[k*WARP_W +: WARP_W];
      end
    end
  end

  // R8: the level count stays within one and DEPTH
  assert_depth_bounds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q >= CW'(1)) && (int'(cnt_q) <= DEPTH));

  // R6: a divergence adds exactly two levels
  assert_diverge_grow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == RS_OP_DIVERGE) |=> (int'(cnt_q) == int'($past(cnt_q)) + 2));

endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
  import rs_pkg::*;
#(
  parameter int              WARP_W   = 32,
  parameter int              PC_W     = 32,
  parameter int              DEPTH    = 8,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       launch_i,
  input  logic [PC_W-1:0]            launch_pc_i,
  input  logic                       br_valid_i,
  output logic                       br_ready_o,
  input  logic [WARP_W-1:0]          br_taken_mask_i,
  input  logic [PC_W-1:0]            br_taken_pc_i,
  input  logic [PC_W-1:0]            br_fall_pc_i,
  input  logic [PC_W-1:0]            br_reconv_pc_i,
  input  logic                       pc_valid_i,
  output logic                       pc_ready_o,
  input  logic [PC_W-1:0]            pc_i,
  output logic [PC_W-1:0]            fetch_pc_o,
  output logic [WARP_W-1:0]          active_mask_o,
  output logic [$clog2(DEPTH+1)-1:0] depth_o,
  output logic                       overflow_o
);

  localparam int CW = $clog2(DEPTH + 1);

  rs_op_e            op;
  logic [PC_W-1:0]   set_pc;
  logic              br_fire;
  logic              pc_fire;
  logic              refuse;
  logic              no_room;
  logic              ovf_q;

  logic [PC_W-1:0]   top_rpc;
  logic              top_rpc_valid;
  logic [PC_W-1:0]   top_pc;
  logic [WARP_W-1:0] top_mask;
  logic [CW-1:0]     depth;

  logic              uniform;
  logic [PC_W-1:0]   uniform_pc;
  logic [WARP_W-1:0] hi_mask;
  logic [PC_W-1:0]   hi_pc;
  logic [WARP_W-1:0] lo_mask;
  logic [PC_W-1:0]   lo_pc;

  rs_branch_eval #(.WARP_W(WARP_W), .PC_W(PC_W)) u_eval (
    .active_i     (top_mask),
    .taken_mask_i (br_taken_mask_i),
    .taken_pc_i   (br_taken_pc_i),
    .fall_pc_i    (br_fall_pc_i),
    .uniform_o    (uniform),
    .uniform_pc_o (uniform_pc),
    .hi_mask_o    (hi_mask),
    .hi_pc_o      (hi_pc),
    .lo_mask_o    (lo_mask),
    .lo_pc_o      (lo_pc)
  );

  rs_entry_file #(
    .WARP_W   (WARP_W),
    .PC_W     (PC_W),
    .DEPTH    (DEPTH),
    .RESET_PC (RESET_PC),
    .CW       (CW)
  ) u_file (
    .clk             (clk),
    .rst_n           (rst_n),
    .op_i            (op),
    .set_pc_i        (set_pc),
    .launch_pc_i     (launch_pc_i),
    .rpc_i           (br_reconv_pc_i),
    .hi_pc_i         (hi_pc),
    .hi_mask_i       (hi_mask),
    .lo_pc_i         (lo_pc),
    .lo_mask_i       (lo_mask),
    .top_rpc_o       (top_rpc),
    .top_rpc_valid_o (top_rpc_valid),
    .top_pc_o        (top_pc),
    .top_mask_o      (top_mask),
    .depth_o         (depth)
  );

  // Launch blocks both streams; a branch beat holds off the PC stream.
  assign br_ready_o = !launch_i;
  assign pc_ready_o = !launch_i && !br_valid_i;
  assign br_fire    = br_valid_i && br_ready_o;
  assign pc_fire    = pc_valid_i && pc_ready_o;
  assign no_room    = (int'(depth) + 2) > DEPTH;

  always_comb begin
    op     = RS_OP_IDLE;
    set_pc = pc_i;
    refuse = 1'b0;
    if (launch_i) begin
      op = RS_OP_LAUNCH;
    end else if (br_fire) begin
      if (uniform) begin
        op     = RS_OP_SET_TOP;
        set_pc = uniform_pc;
      end else if (no_room) begin
        refuse = 1'b1;
      end else begin
        op = RS_OP_DIVERGE;
      end
    end else if (pc_fire) begin
      if (top_rpc_valid && (pc_i == top_rpc)) begin
        op = RS_OP_POP;
      end else begin
        op = RS_OP_SET_TOP;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
    end else if (launch_i) begin
      ovf_q <= 1'b0;
    end else if (refuse) begin
      ovf_q <= 1'b1;
    end
  end

  assign fetch_pc_o    = top_pc;
  assign active_mask_o = top_mask;
  assign depth_o       = depth;
  assign overflow_o    = ovf_q;

  // R2: a launch leaves one full-mask level and a clear flag
  assert_launch_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
    launch_i |=> (depth_o == CW'(1)) && !overflow_o && (active_mask_o == '1));

  // R4: a pop removes exactly one level
  assert_pop_depth_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == RS_OP_POP) |=> (int'(depth_o) == int'($past(depth_o)) - 1));

  // R5: a uniform branch keeps the depth
  assert_uniform_depth_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (br_fire && uniform && !launch_i) |=> $stable(depth_o));

  // R6: the top level never runs with no threads
  assert_mask_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    active_mask_o != '0);

  // R8: a refused push leaves the stack as it was and raises the flag
  assert_refuse_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    refuse |=> $stable(depth_o) && $stable(fetch_pc_o) && overflow_o);

  // R8: the flag holds until launch
  assert_no_overflow_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow_o && !launch_i) |=> overflow_o);

endmodule

// File: tb/simt_reconv_stack_tb.sv
module simt_reconv_stack_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WARP_W = 4;
  localparam int PC_W   = 16;
  localparam int DEPTH  = 5;
  localparam int CW     = $clog2(DEPTH + 1);
  localparam logic [PC_W-1:0] RESET_PC = 16'h0010;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              launch_i = 1'b0;
  logic [PC_W-1:0]   launch_pc_i = '0;
  logic              br_valid_i = 1'b0;
  logic              br_ready_o;
  logic [WARP_W-1:0] br_taken_mask_i = '0;
  logic [PC_W-1:0]   br_taken_pc_i = '0;
  logic [PC_W-1:0]   br_fall_pc_i = '0;
  logic [PC_W-1:0]   br_reconv_pc_i = '0;
  logic              pc_valid_i = 1'b0;
  logic              pc_ready_o;
  logic [PC_W-1:0]   pc_i = '0;
  logic [PC_W-1:0]   fetch_pc_o;
  logic [WARP_W-1:0] active_mask_o;
  logic [CW-1:0]     depth_o;
  logic              overflow_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simt_reconv_stack #(
    .WARP_W(WARP_W), .PC_W(PC_W), .DEPTH(DEPTH), .RESET_PC(RESET_PC)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .launch_i(launch_i), .launch_pc_i(launch_pc_i),
    .br_valid_i(br_valid_i), .br_ready_o(br_ready_o),
    .br_taken_mask_i(br_taken_mask_i), .br_taken_pc_i(br_taken_pc_i),
    .br_fall_pc_i(br_fall_pc_i), .br_reconv_pc_i(br_reconv_pc_i),
    .pc_valid_i(pc_valid_i), .pc_ready_o(pc_ready_o), .pc_i(pc_i),
    .fetch_pc_o(fetch_pc_o), .active_mask_o(active_mask_o),
    .depth_o(depth_o), .overflow_o(overflow_o)
  );

  // kind 0: PC beat (a = pc); kind 1: branch (tmask, a = taken, b = fall, c = join)
  typedef struct packed {
    logic        kind;
    logic [3:0]  tmask;
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] c;
    logic [15:0] epc;
    logic [3:0]  emask;
    logic [3:0]  edepth;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 4'h0, 16'h0011, 16'h0000, 16'h0000, 16'h0011, 4'hF, 4'd1, 8'd3}, // R3
    '{1'b1, 4'h5, 16'h0020, 16'h0040, 16'h0050, 16'h0020, 4'h5, 4'd3, 8'd7}, // R7 tie
    '{1'b0, 4'h0, 16'h0021, 16'h0000, 16'h0000, 16'h0021, 4'h5, 4'd3, 8'd3}, // R3
    '{1'b1, 4'h1, 16'h0030, 16'h0038, 16'h003C, 16'h0030, 4'h1, 4'd5, 8'd6}, // R6 nested
    '{1'b0, 4'h0, 16'h003C, 16'h0000, 16'h0000, 16'h0038, 4'h4, 4'd4, 8'd4}, // R4
    '{1'b0, 4'h0, 16'h0039, 16'h0000, 16'h0000, 16'h0039, 4'h4, 4'd4, 8'd3}, // R3
    '{1'b0, 4'h0, 16'h003C, 16'h0000, 16'h0000, 16'h003C, 4'h5, 4'd3, 8'd4}, // R4
    '{1'b0, 4'h0, 16'h003D, 16'h0000, 16'h0000, 16'h003D, 4'h5, 4'd3, 8'd3}, // R3
    '{1'b0, 4'h0, 16'h0050, 16'h0000, 16'h0000, 16'h0040, 4'hA, 4'd2, 8'd4}, // R4
    '{1'b0, 4'h0, 16'h0041, 16'h0000, 16'h0000, 16'h0041, 4'hA, 4'd2, 8'd3}, // R3
    '{1'b0, 4'h0, 16'h0050, 16'h0000, 16'h0000, 16'h0050, 4'hF, 4'd1, 8'd4}, // R4
    '{1'b0, 4'h0, 16'h0050, 16'h0000, 16'h0000, 16'h0050, 4'hF, 4'd1, 8'd3}, // R3 bottom never pops
    '{1'b1, 4'h1, 16'h0060, 16'h0070, 16'h0080, 16'h0070, 4'hE, 4'd3, 8'd7}, // R7 busier fall path
    '{1'b1, 4'hE, 16'h0074, 16'h0072, 16'h0000, 16'h0074, 4'hE, 4'd3, 8'd5}, // R5 all taken
    '{1'b1, 4'h1, 16'h0099, 16'h0076, 16'h0000, 16'h0076, 4'hE, 4'd3, 8'd5}, // R5 inactive bit
    '{1'b0, 4'h0, 16'h0080, 16'h0000, 16'h0000, 16'h0060, 4'h1, 4'd2, 8'd4}, // R4
    '{1'b0, 4'h0, 16'h0080, 16'h0000, 16'h0000, 16'h0080, 4'hF, 4'd1, 8'd4}  // R4
  };

  task automatic check(input string tag, input logic [PC_W-1:0] epc,
                       input logic [WARP_W-1:0] emask, input int edepth, input logic eovf);
    checks++;
    if (fetch_pc_o !== epc || active_mask_o !== emask ||
        int'(depth_o) != edepth || overflow_o !== eovf) begin
      errors++;
      $display("FAIL %s: pc=%h mask=%h depth=%0d ovf=%b expected pc=%h mask=%h depth=%0d ovf=%b",
               tag, fetch_pc_o, active_mask_o, depth_o, overflow_o, epc, emask, edepth, eovf);
    end
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic branch(input logic [3:0] m, input logic [15:0] tpc,
                        input logic [15:0] fpc, input logic [15:0] rpc);
    br_valid_i = 1'b1; br_taken_mask_i = m; br_taken_pc_i = tpc;
    br_fall_pc_i = fpc; br_reconv_pc_i = rpc;
    step();
    br_valid_i = 1'b0;
  endtask

  task automatic advance(input logic [15:0] p);
    pc_valid_i = 1'b1; pc_i = p;
    step();
    pc_valid_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset state", RESET_PC, 4'hF, 1, 1'b0);
    check_bit("R1 branch ready after reset", br_ready_o, 1'b1);

    for (int k = 0; k < NV; k++) begin
      if (VEC[k].kind) branch(VEC[k].tmask, VEC[k].a, VEC[k].b, VEC[k].c);
      else advance(VEC[k].a);
      check($sformatf("R%0d vector %0d", VEC[k].req, k),
            VEC[k].epc, VEC[k].emask, int'(VEC[k].edepth), 1'b0);
    end

    // R7: busier path (taken, 3 threads) on top
    branch(4'h7, 16'h0090, 16'h0098, 16'h00A0);
    check("R7 taken busier", 16'h0090, 4'h7, 3, 1'b0);
    // R8: push that fills the stack exactly to DEPTH; fall path busier
    branch(4'h1, 16'h00B0, 16'h00B8, 16'h00C0);
    check("R8 fill to depth", 16'h00B8, 4'h6, 5, 1'b0);
    // R8: push beyond DEPTH refused
    branch(4'h2, 16'h00D0, 16'h00D8, 16'h00E0);
    check("R8 overflow refused", 16'h00B8, 4'h6, 5, 1'b1);
    // R8: sticky through a uniform branch (R5 at full depth)
    branch(4'h6, 16'h00BC, 16'h00BE, 16'h0000);
    check("R8 sticky after uniform", 16'h00BC, 4'h6, 5, 1'b1);

    // R9: collision; PC equals the top join PC but must wait
    br_valid_i = 1'b1; br_taken_mask_i = 4'h0; br_taken_pc_i = 16'h00F0;
    br_fall_pc_i = 16'h00C4; br_reconv_pc_i = 16'h0000;
    pc_valid_i = 1'b1; pc_i = 16'h00C0;
    #1;
    check_bit("R9 pc ready low on collision", pc_ready_o, 1'b0);
    check_bit("R9 branch ready on collision", br_ready_o, 1'b1);
    step();
    br_valid_i = 1'b0;
    check("R9 branch wins", 16'h00C4, 4'h6, 5, 1'b1);
    #1;
    check_bit("R9 pc ready after branch", pc_ready_o, 1'b1);
    step();
    pc_valid_i = 1'b0;
    check("R9 held pc pops (R4)", 16'h00B0, 4'h1, 4, 1'b1);

    // R2: launch
    launch_i = 1'b1; launch_pc_i = 16'h0200;
    #1;
    check_bit("R2 branch ready low in launch", br_ready_o, 1'b0);
    check_bit("R2 pc ready low in launch", pc_ready_o, 1'b0);
    step();
    launch_i = 1'b0;
    check("R2 launch state", 16'h0200, 4'hF, 1, 1'b0);
    advance(16'h0200);
    check("R2 bottom level has no join", 16'h0200, 4'hF, 1, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule